// File: doc/BRIEF.md
# Start-Up Delay Sequencer

This block keeps a chip's internal reset asserted after an external reset or power-on. It lets the reset go only once a configurable start-up delay has run out. The delay always begins with a fixed run of system clock cycles. A 2-bit configuration code can then add a second wait, counted in ticks of a slow, free-running watchdog oscillator that is unrelated to the system clock. This gives slowly rising supplies time to settle before any logic leaves reset.

Waking from a power-down sleep uses a separate, much shorter path. While the system is asleep the internal reset stays released and only the ready flag drops. When the wake request goes away, the flag returns after a short fixed count of system clock cycles, and no oscillator ticks are needed. A clock-unstable hold input forces the whole sequence back to its start, so the clock's frequency can be moved safely while it is held.

Top module: `startup_delay_seq`

## Requirements
- R1: Driving `rst_ext_n` low forces `sys_rst_n` and `ready` low at once, without waiting for a clock edge.
- R2: With code 2'b00, and with `rst_ext_n` high and `clk_hold` low, `sys_rst_n` and `ready` rise at the 14th rising clock edge after reset is removed. No watchdog ticks are needed.
- R3: With code 2'b01, the 14 clock cycles are followed by 512 counted watchdog ticks. The release happens at the clock edge that counts the 512th tick.
- R4: With code 2'b10, the 14 clock cycles are followed by 8192 counted watchdog ticks before release.
- R5: Code 2'b11 gives exactly the same delay as code 2'b10.
- R6: A rising edge on `wdt_tick` is counted at the third rising clock edge after it occurs. A tick that stays high for many cycles counts once. Ticks seen during the clock-cycle phase are not counted.
- R7: While `clk_hold` is high, `sys_rst_n` and `ready` are low, in the same cycle. After the hold falls, the sequence restarts from the first of the 14 clock cycles.
- R8: `ready` never rises before `sys_rst_n`. After a reset sequence, both rise in the same cycle.
- R9: While running, a high `wake_req` drops `ready` and keeps `sys_rst_n` high. `ready` returns at the 6th rising edge after `wake_req` falls, for every code. A new `wake_req` during that count restarts it.
- R10: `wake_req` has no effect while the reset sequence is still counting.
- R11: The code is sampled at the 14th clock edge. Later changes to the code do not alter the wait in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_ext_n | input | 1 | External or power-on reset, active low, asserted asynchronously |
| wdt_tick | input | 1 | Raw tick from the slow watchdog oscillator (asynchronous) |
| wake_req | input | 1 | High while in power-down; falling edge starts the wake delay |
| clk_hold | input | 1 | High while the system clock is not stable |
| delay_code | input | 2 | Start-up delay selection code |
| sys_rst_n | output | 1 | Internal reset, active low |
| ready | output | 1 | High when the system may run |

## Verification
The assertions assume that `rst_ext_n` is removed away from a clock edge and that `clk_hold` and `wake_req` change only between edges, as synchronous levels. They also assume that `wdt_tick` pulses are at least one clock long. The bench drives every input a short time after a rising edge. Its tick generator makes pulses two or more cycles wide, including long high stretches, so each oscillator edge is seen by the synchronizer. The reference model therefore reasons only about values sampled at clock edges.

// File: rtl/startup_delay_pkg.sv
package startup_delay_pkg;

  typedef enum logic [2:0] {
    ST_CYC  = 3'd0,
    ST_TICK = 3'd1,
    ST_RUN  = 3'd2,
    ST_PD   = 3'd3,
    ST_WAKE = 3'd4
  } seq_state_t;

  // Number of oscillator ticks that follow the clock phase; 0 means none.
  // The reserved code falls back to the longest wait.
  function automatic int unsigned tick_limit(input logic [1:0] code,
                                             input int unsigned short_n,
                                             input int unsigned long_n);
    case (code)
      2'b00:   return 0;
      2'b01:   return short_n;
      default: return long_n;
    endcase
  endfunction

  function automatic logic reset_released(input seq_state_t st);
    return (st == ST_RUN) || (st == ST_PD) || (st == ST_WAKE);
  endfunction

endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_tick,
  output logic tick_edge
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= raw_tick;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[LAST];
  end

  assign tick_edge = stage_q[LAST] & ~prev_q;

  // R6: a detected edge lasts exactly one cycle
  p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_edge |=> !tick_edge);

endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld_one,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (clr)    value <= '0;
    else if (ld_one) value <= W'(1);
    else if (inc)    value <= value + W'(1);
  end

  // R3: the counter must never wrap
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !ld_one) |-> (value != '1));

endmodule

// File: rtl/startup_delay_fsm.sv
module startup_delay_fsm
  import startup_delay_pkg::*;
#(
  parameter int CYC_DELAY   = 14,
  parameter int WAKE_DELAY  = 6,
  parameter int TICKS_SHORT = 512,
  parameter int TICKS_LONG  = 8192,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             wake,
  input  logic             tick_edge,
  input  logic [1:0]       code,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_ld_one,
  output logic             cnt_inc,
  output logic             released,
  output logic             running
);
  localparam logic [CNT_W-1:0] CYC_LAST  = CNT_W'(CYC_DELAY - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_DELAY - 1);

  seq_state_t       state_q, state_d;
  logic [1:0]       cfg_q;
  logic             cfg_load;
  logic [CNT_W-1:0] lim_cfg;
  logic             now_none;

  assign lim_cfg  = CNT_W'(tick_limit(cfg_q, TICKS_SHORT, TICKS_LONG));
  assign now_none = (tick_limit(code, TICKS_SHORT, TICKS_LONG) == 0);

  always_comb begin
    state_d    = state_q;
    cnt_clr    = 1'b0;
    cnt_ld_one = 1'b0;
    cnt_inc    = 1'b0;
    cfg_load   = 1'b0;
    if (hold) begin
      state_d = ST_CYC;
      cnt_clr = 1'b1;
    end else begin
      case (state_q)
        ST_CYC: begin
          if (cnt == CYC_LAST) begin
            cfg_load = 1'b1;
            cnt_clr  = 1'b1;
            state_d  = now_none ? ST_RUN : ST_TICK;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_TICK: begin
          if (tick_edge) begin
            if (cnt == lim_cfg - CNT_W'(1)) begin
              cnt_clr = 1'b1;
              state_d = ST_RUN;
            end else begin
              cnt_inc = 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (wake) state_d = ST_PD;
        end
        ST_PD: begin
          if (!wake) begin
            cnt_ld_one = 1'b1;
            state_d    = ST_WAKE;
          end
        end
        ST_WAKE: begin
          if (wake) begin
            cnt_clr = 1'b1;
            state_d = ST_PD;
          end else if (cnt == WAKE_LAST) begin
            cnt_clr = 1'b1;
            state_d = ST_RUN;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        default: begin
          cnt_clr = 1'b1;
          state_d = ST_CYC;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CYC;
      cfg_q   <= 2'b11;
    end else begin
      state_q <= state_d;
      if (cfg_load) cfg_q <= code;
    end
  end

  assign released = reset_released(state_q);
  assign running  = (state_q == ST_RUN);

  // R4: the tick count stays below the selected limit
  p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TICK) |-> (cnt < lim_cfg));

  // R7: a hold sends the sequence back to its first cycle
  p_hold_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (state_q == ST_CYC && cnt == '0));

  // R9: the wake path never enters the tick phase
  p_wake_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PD || state_q == ST_WAKE) |=> (state_q != ST_TICK));

  // R10: power-down is unreachable while still counting
  p_wake_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CYC || state_q == ST_TICK) |=> (state_q != ST_PD));

  // R2: the clock phase never lasts longer than its count
  p_cyc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CYC) |-> (cnt <= CYC_LAST));

endmodule

// File: rtl/startup_delay_seq.sv
module startup_delay_seq #(
  parameter int CYC_DELAY   = 14,
  parameter int WAKE_DELAY  = 6,
  parameter int TICKS_SHORT = 512,
  parameter int TICKS_LONG  = 8192,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_ext_n,
  input  logic       wdt_tick,
  input  logic       wake_req,
  input  logic       clk_hold,
  input  logic [1:0] delay_code,
  output logic       sys_rst_n,
  output logic       ready
);
  localparam int MAX_A = (TICKS_LONG > TICKS_SHORT) ? TICKS_LONG : TICKS_SHORT;
  localparam int MAX_B = (CYC_DELAY > WAKE_DELAY) ? CYC_DELAY : WAKE_DELAY;
  localparam int MAX_N = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_N + 1);

  logic             tick_edge;
  logic             cnt_clr, cnt_ld_one, cnt_inc;
  logic [CNT_W-1:0] cnt;
  logic             released, running;

  tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_ext_n),
    .raw_tick (wdt_tick),
    .tick_edge(tick_edge)
  );

  seq_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_ext_n),
    .clr   (cnt_clr),
    .ld_one(cnt_ld_one),
    .inc   (cnt_inc),
    .value (cnt)
  );

  startup_delay_fsm #(
    .CYC_DELAY  (CYC_DELAY),
    .WAKE_DELAY (WAKE_DELAY),
    .TICKS_SHORT(TICKS_SHORT),
    .TICKS_LONG (TICKS_LONG),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_ext_n),
    .hold      (clk_hold),
    .wake      (wake_req),
    .tick_edge (tick_edge),
    .code      (delay_code),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .cnt_ld_one(cnt_ld_one),
    .cnt_inc   (cnt_inc),
    .released  (released),
    .running   (running)
  );

  assign sys_rst_n = rst_ext_n & ~clk_hold & released;
  assign ready     = rst_ext_n & ~clk_hold & running;

  // R8: ready is only seen with the reset released
  p_ready_needs_release_r8: assert property (@(posedge clk) disable iff (!rst_ext_n)
    ready |-> sys_rst_n);

  // R7: a hold always keeps the reset asserted
  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_ext_n)
    clk_hold |-> (!sys_rst_n && !ready));

  // R1: immediate check that the external reset dominates
  always_comb begin
    if (!rst_ext_n) p_ext_reset_r1: assert (!sys_rst_n && !ready);
  end

endmodule

// File: tb/startup_delay_seq_test.sv
module startup_delay_seq_test;
  logic       clk = 1'b0;
  logic       rst_ext_n = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       wake_req = 1'b0;
  logic       clk_hold = 1'b0;
  logic [1:0] delay_code = 2'b00;
  logic       sys_rst_n, ready;

  int vectors = 0;
  int fails = 0;
  int cycle_no = 0;
  string cur_req = "R1";

  bit tick_en = 1'b0;
  int tick_hi = 2, tick_lo = 2, tick_ctr = 0;

  always #10 clk = ~clk;

  startup_delay_seq uut (
    .clk(clk), .rst_ext_n(rst_ext_n), .wdt_tick(wdt_tick), .wake_req(wake_req),
    .clk_hold(clk_hold), .delay_code(delay_code), .sys_rst_n(sys_rst_n), .ready(ready)
  );

  // Behavioural reference: phase 0 clocks, 1 ticks, 2 run, 3 asleep, 4 waking
  int m_phase = 0;
  int m_cnt = 0;
  int m_lim = 0;
  bit raw_q[$] = '{1'b0, 1'b0, 1'b0};

  always @(posedge clk) begin
    if (!rst_ext_n) begin
      m_phase = 0; m_cnt = 0;
      raw_q = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit seen;
      seen = raw_q[1] && !raw_q[2];
      if (clk_hold) begin
        m_phase = 0; m_cnt = 0;
      end else begin
        case (m_phase)
          0: begin
            m_cnt++;
            if (m_cnt == 14) begin
              m_lim = (delay_code == 2'b00) ? 0 : (delay_code == 2'b01) ? 512 : 8192;
              m_phase = (m_lim == 0) ? 2 : 1;
              m_cnt = 0;
            end
          end
          1: if (seen) begin
            m_cnt++;
            if (m_cnt == m_lim) begin m_phase = 2; m_cnt = 0; end
          end
          2: if (wake_req) m_phase = 3;
          3: if (!wake_req) begin m_phase = 4; m_cnt = 1; end
          default: begin
            if (wake_req) begin m_phase = 3; m_cnt = 0; end
            else begin
              m_cnt++;
              if (m_cnt == 6) begin m_phase = 2; m_cnt = 0; end
            end
          end
        endcase
      end
      raw_q.push_front(wdt_tick);
      void'(raw_q.pop_back());
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", cur_req, what, act, exp, cycle_no);
    end
  endtask

  always @(negedge clk) begin
    logic e_rel, e_rdy;
    e_rel = rst_ext_n && !clk_hold && (m_phase >= 2);
    e_rdy = rst_ext_n && !clk_hold && (m_phase == 2);
    check(sys_rst_n, e_rel, "sys_rst_n");
    check(ready, e_rdy, "ready");
  end

  always @(posedge clk) begin
    cycle_no++;
    if (cycle_no > 190000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    if (tick_en) begin
      tick_ctr++;
      wdt_tick = (tick_ctr % (tick_hi + tick_lo)) < tick_hi;
    end else begin
      wdt_tick = 1'b0;
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic until_ready(input int max_n, output int took);
    took = 0;
    while (!ready && took < max_n) begin step(); took++; end
  endtask

  task automatic do_reset();
    rst_ext_n = 1'b0;
    cycles(3);
    rst_ext_n = 1'b1;
  endtask

  initial begin
    int took;
    // R1 reset state
    cur_req = "R1";
    cycles(3);
    check(sys_rst_n, 1'b0, "reset state rst");
    check(ready, 1'b0, "reset state ready");

    // R2 / R8 code 00, exact release edge
    cur_req = "R2 R8";
    delay_code = 2'b00;
    rst_ext_n = 1'b1;
    until_ready(100, took);
    vectors++;
    if (took != 14) begin fails++; $display("FAIL R2 release edge: actual %0d expected 14", took); end
    check(sys_rst_n, 1'b1, "released with ready");
    cycles(5);

    // R9 wake delay, code 00
    cur_req = "R9";
    wake_req = 1'b1; cycles(5);
    check(sys_rst_n, 1'b1, "rst stays released asleep");
    wake_req = 1'b0;
    until_ready(100, took);
    vectors++;
    if (took != 6) begin fails++; $display("FAIL R9 wake edge: actual %0d expected 6", took); end
    // restart of wake count
    wake_req = 1'b1; cycles(2); wake_req = 1'b0; cycles(3);
    wake_req = 1'b1; cycles(1); wake_req = 1'b0; cycles(10);

    // R1 asynchronous assertion mid-cycle
    cur_req = "R1";
    @(negedge clk); #3;
    rst_ext_n = 1'b0; #1;
    check(sys_rst_n, 1'b0, "async rst");
    check(ready, 1'b0, "async ready");
    cycles(2);

    // R7 hold during clock phase and during run
    cur_req = "R7";
    rst_ext_n = 1'b1; cycles(8);
    clk_hold = 1'b1; cycles(3); clk_hold = 1'b0;
    until_ready(100, took);
    vectors++;
    if (took != 14) begin fails++; $display("FAIL R7 restart edge: actual %0d expected 14", took); end
    clk_hold = 1'b1; cycles(1);
    check(ready, 1'b0, "hold drops ready");
    clk_hold = 1'b0; cycles(20);

    // R3 / R6 / R10 code 01, ticks running through the clock phase
    cur_req = "R3 R6 R10";
    delay_code = 2'b01; tick_en = 1'b1; tick_hi = 2; tick_lo = 2;
    do_reset();
    wake_req = 1'b1; cycles(6); wake_req = 1'b0;
    cycles(300); wake_req = 1'b1; cycles(3); wake_req = 1'b0;
    until_ready(4000, took);
    check(ready, 1'b1, "code 01 released");
    cycles(10);

    // R6 long high ticks count once; R11 code change after sampling
    cur_req = "R6 R11";
    tick_hi = 9; tick_lo = 3;
    do_reset();
    cycles(20);
    delay_code = 2'b00;
    until_ready(8000, took);
    vectors++;
    if (took < 512 * 12 - 60) begin fails++; $display("FAIL R11 short wait: actual %0d expected >= %0d", took, 512 * 12 - 60); end
    cycles(10);

    // R7 hold during tick phase restarts the whole sequence
    cur_req = "R7";
    tick_hi = 2; tick_lo = 2; delay_code = 2'b01;
    do_reset(); cycles(400);
    clk_hold = 1'b1; cycles(2); clk_hold = 1'b0;
    until_ready(4000, took);
    check(ready, 1'b1, "restart then release");

    // R4 code 10
    cur_req = "R4";
    delay_code = 2'b10;
    do_reset();
    until_ready(40000, took);
    check(ready, 1'b1, "code 10 released");
    // R9 wake delay ignores the code
    cur_req = "R9";
    wake_req = 1'b1; cycles(4); wake_req = 1'b0;
    until_ready(100, took);
    vectors++;
    if (took != 6) begin fails++; $display("FAIL R9 wake edge code 10: actual %0d expected 6", took); end

    // R5 code 11 equals code 10
    cur_req = "R5";
    delay_code = 2'b11;
    do_reset();
    until_ready(40000, took);
    check(ready, 1'b1, "code 11 released");
    cycles(10);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule